// File: doc/BRIEF.md
# Time alarm and fixed-period pulse generator

The block follows a 64-bit nanosecond time value supplied by a separate time counter. It compares that time against two programmable alarm values and against per-channel pulse deadlines. Comparisons are made only on cycles where the counter's tick strobe is high. When the time reaches or passes an armed alarm value, the block drives a one-cycle alarm pin pulse and latches an event bit. The alarm then stays disarmed until software writes the upper half of that alarm again.

Three periodic pulse channels each emit a one-cycle pulse every time the time advances by their programmed interval. By default they do not free-run. Once the start bit is set, each channel waits for the first alarm's match and anchors its interval count at the time of that match. Software normally places that alarm one clock period before a whole second, so the pulses fall on second boundaries. A second control bit turns realignment off. In that mode each channel anchors at the first tick after the start bit is set and ignores the alarm.

Every alarm and pulse sets a bit in a write-one-to-clear event register. An enable mask with the same layout gates these bits onto a single interrupt line. All configuration arrives on a simple write-only register bus.

Top module: `tmr_alarm_pulse`

## Requirements
- R1: After reset, alarm_o and pulse_o are all zero, irq_o is low, both alarms are disarmed and the pulse channels are stopped.
- R2: An armed alarm matches on the first tick where time_i, compared as unsigned 64 bits, is greater than or equal to its value, including when the step overshoots the value. The alarm pin shows the match in the cycle after that tick, for one cycle. Alarm k has its low word at address 3+2k and its high word at address 4+2k.
- R3: A match disarms the alarm, so it fires exactly once. Only a write to its high-word address arms it again.
- R4: No comparison is made on cycles with tick_i low, however far time_i has passed the alarm value.
- R5: Control register (address 0) bit 31 inverts alarm pin 0 and bit 30 inverts alarm pin 1. An inverted pin idles high and pulses low.
- R6: Event register (address 1) bit 16 is set by an alarm 0 match and bit 17 by an alarm 1 match. Bits 7, 6 and 5 are set by pulses on channels 0, 1 and 2. Writing 1 to a bit clears it and writing 0 leaves it unchanged. irq_o is high while any event bit and the bit at the same position of the mask register (address 2) are both set.
- R7: Clearing a mask bit drops irq_o without clearing the pending event. Setting the mask bit again raises irq_o.
- R8: Pulses are produced only while control bit 28 (start) is set. Clearing the start bit stops all channels.
- R9: With control bit 14 clear, a started channel emits no pulse before an alarm 0 match. After the match, channel k pulses one cycle after each tick whose time reaches the match time plus n times its period (address 7+k), with n at least 1.
- R10: With control bit 14 set, a channel anchors at the first tick after the start bit is set, and alarm 0 matches do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current time in nanoseconds from the time counter |
| tick_i | input | 1 | Tick strobe; comparisons run only when high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| alarm_o | output | 2 | Alarm pins, one-cycle pulses with programmable polarity |
| pulse_o | output | 3 | Periodic pulse pins, one per channel |
| irq_o | output | 1 | Interrupt, OR of enabled event bits |

## Verification
The hardest condition to reach is a pulse channel that has been started but has not yet aligned. In that state the start bit is set and the time is already well past several periods, yet nothing may come out until the first alarm matches. The stimulus therefore writes all three periods and the start bit before arming alarm 0 in the middle of a time ramp. Every observed cycle is then compared with pulse times derived from the alarm time. A second run arms the alarm inside the ramp with realignment off, showing that the anchor stays on the first tick. Events are observed through the mask and interrupt line, since the bus has no read path.

// File: rtl/tmr_alarm_pulse_pkg.sv
package tmr_alarm_pulse_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVT      = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK     = 4'd2;
  localparam logic [ADDR_W-1:0] A_ALM_BASE = 4'd3;  // lo at base+2k, hi at base+2k+1
  localparam logic [ADDR_W-1:0] A_PER_BASE = 4'd7;

  localparam int B_ALM_EVT = 16;  // alarm k -> 16+k
  localparam int B_PUL_EVT = 7;   // channel k -> 7-k
  localparam int B_ALM_POL = 31;  // alarm k -> 31-k
  localparam int B_START   = 28;
  localparam int B_NOALIGN = 14;
endpackage

// File: rtl/tmr_alarm_cmp.sv
module tmr_alarm_cmp #(
  parameter int TIME_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pol_i,
  output logic              hit_o,
  output logic              pin_o
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [TIME_W-1:0] cmp_q;
  logic              armed_q;
  logic              hit_q;

  assign hit_o = tick_i && armed_q && (time_i >= cmp_q);
  assign pin_o = hit_q ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= hit_o;
      if (wr_lo_i) cmp_q[DATA_W-1:0] <= wr_data_i;
      if (wr_hi_i) begin
        cmp_q[TIME_W-1:DATA_W] <= wr_data_i[HI_W-1:0];
        armed_q                <= 1'b1;
      end else if (hit_o) begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_pulse_chan.sv
module tmr_pulse_chan #(
  parameter int TIME_W = 64,
  parameter int PER_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              run_i,
  input  logic              noalign_i,
  input  logic              align_i,
  output logic              fire_o,
  output logic              pulse_o
);
  logic              active_q;
  logic [TIME_W-1:0] target_q;
  logic [TIME_W-1:0] per_ext;
  logic              anchor;

  assign per_ext = {{(TIME_W-PER_W){1'b0}}, period_i};
  // realign mode anchors on alarm match, free mode on first tick after start
  assign anchor  = noalign_i ? (!active_q && tick_i) : align_i;
  assign fire_o  = run_i && active_q && tick_i && !(align_i && !noalign_i)
                   && (time_i >= target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      target_q <= '0;
      pulse_o  <= 1'b0;
    end else begin
      pulse_o <= fire_o;
      if (!run_i || period_i == '0) begin
        active_q <= 1'b0;
      end else if (anchor) begin
        active_q <= 1'b1;
        target_q <= time_i + per_ext;
      end else if (fire_o) begin
        target_q <= target_q + per_ext;
      end
    end
  end
endmodule

// File: rtl/tmr_event_reg.sv
module tmr_event_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_wr_i,
  input  logic              mask_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] evt_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] clr;

  assign clr   = clr_wr_i ? wr_data_i : '0;
  assign irq_o = |(evt_o & mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o  <= '0;
      mask_o <= '0;
    end else begin
      evt_o <= (evt_o & ~clr) | set_i;  // new events win over a same-cycle clear
      if (mask_wr_i) mask_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/tmr_alarm_pulse.sv
module tmr_alarm_pulse
  import tmr_alarm_pulse_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int PER_W   = 32,
  parameter int N_ALARM = 2,
  parameter int N_PULSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_ALARM-1:0] alarm_o,
  output logic [N_PULSE-1:0] pulse_o,
  output logic              irq_o
);
  logic               ctrl_start;
  logic               ctrl_noalign;
  logic [N_ALARM-1:0] alm_pol;
  logic [N_ALARM-1:0] alm_hit;
  logic [N_PULSE-1:0] pul_fire;
  logic [DATA_W-1:0]  set_vec;
  logic [DATA_W-1:0]  evt_q;
  logic [DATA_W-1:0]  mask_q;
  logic               wr_ctrl;

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_start   <= 1'b0;
      ctrl_noalign <= 1'b0;
      alm_pol      <= '0;
    end else if (wr_ctrl) begin
      ctrl_start   <= wr_data_i[B_START];
      ctrl_noalign <= wr_data_i[B_NOALIGN];
      for (int k = 0; k < N_ALARM; k++) alm_pol[k] <= wr_data_i[B_ALM_POL-k];
    end
  end

  for (genvar k = 0; k < N_ALARM; k++) begin : g_alm
    localparam logic [ADDR_W-1:0] LO = A_ALM_BASE + ADDR_W'(2*k);
    localparam logic [ADDR_W-1:0] HI = A_ALM_BASE + ADDR_W'(2*k + 1);
    tmr_alarm_cmp #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_cmp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .time_i   (time_i),
      .wr_lo_i  (wr_en_i && (wr_addr_i == LO)),
      .wr_hi_i  (wr_en_i && (wr_addr_i == HI)),
      .wr_data_i(wr_data_i),
      .pol_i    (alm_pol[k]),
      .hit_o    (alm_hit[k]),
      .pin_o    (alarm_o[k])
    );
  end

  for (genvar k = 0; k < N_PULSE; k++) begin : g_pul
    localparam logic [ADDR_W-1:0] PA = A_PER_BASE + ADDR_W'(k);
    logic [PER_W-1:0] per_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q <= '0;
      else if (wr_en_i && (wr_addr_i == PA)) per_q <= wr_data_i[PER_W-1:0];
    end
    tmr_pulse_chan #(.TIME_W(TIME_W), .PER_W(PER_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .time_i   (time_i),
      .period_i (per_q),
      .run_i    (ctrl_start),
      .noalign_i(ctrl_noalign),
      .align_i  (alm_hit[0]),
      .fire_o   (pul_fire[k]),
      .pulse_o  (pulse_o[k])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < N_ALARM; k++) set_vec[B_ALM_EVT+k] = alm_hit[k];
    for (int k = 0; k < N_PULSE; k++) set_vec[B_PUL_EVT-k] = pul_fire[k];
  end

  tmr_event_reg #(.DATA_W(DATA_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_wr_i (wr_en_i && (wr_addr_i == A_EVT)),
    .mask_wr_i(wr_en_i && (wr_addr_i == A_MASK)),
    .wr_data_i(wr_data_i),
    .evt_o    (evt_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/tmr_alarm_pulse_chk.sv
module tmr_alarm_pulse_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       hit0_i,
  input logic       arm0_i,
  input logic       pin0_i,
  input logic       pol0_i,
  input logic [2:0] pulse_i,
  input logic       start_i,
  input logic       evt_alm0_i,
  input logic       evt_pul0_i,
  input logic       mask_zero_i,
  input logic       irq_i
);
  // R3
  alarm_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit0_i && !arm0_i) |=> !hit0_i);

  // R4
  alarm_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin0_i ^ pol0_i) |-> $past(tick_i));

  // R6
  alarm_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit0_i |=> evt_alm0_i);

  // R6
  pulse_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i[0] |-> evt_pul0_i);

  // R8
  pulse_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_i) |-> $past(start_i));

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_zero_i |-> !irq_i);
endmodule

bind tmr_alarm_pulse tmr_alarm_pulse_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .hit0_i     (alm_hit[0]),
  .arm0_i     (wr_en_i && (wr_addr_i == tmr_alarm_pulse_pkg::A_ALM_BASE + 4'd1)),
  .pin0_i     (alarm_o[0]),
  .pol0_i     (alm_pol[0]),
  .pulse_i    (pulse_o),
  .start_i    (ctrl_start),
  .evt_alm0_i (evt_q[tmr_alarm_pulse_pkg::B_ALM_EVT]),
  .evt_pul0_i (evt_q[tmr_alarm_pulse_pkg::B_PUL_EVT]),
  .mask_zero_i(mask_q == '0),
  .irq_i      (irq_o)
);

// File: tb/sim_tmr_alarm_pulse.sv
module sim_tmr_alarm_pulse;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] time_i = '0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  alarm_o;
  logic [2:0]  pulse_o;
  logic        irq_o;

  always #2 clk_i = ~clk_i;

  tmr_alarm_pulse u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_i), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .alarm_o(alarm_o), .pulse_o(pulse_o), .irq_o(irq_o)
  );

  int n_run = 0;
  int n_fail = 0;

  logic [1:0]  o_alm;
  logic [2:0]  o_pul;
  logic        o_irq;
  logic [63:0] o_t;
  logic        o_tk;

  typedef struct packed {
    logic [63:0] alm;
    logic [63:0] t0;
    logic [63:0] stp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{64'd100, 64'd0, 64'd10},
    '{64'd105, 64'd0, 64'd10},
    '{64'd50, 64'd60, 64'd10},
    '{64'h0000_0001_0000_0010, 64'h0000_0000_FFFF_FFF0, 64'd8},
    '{64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FE00, 64'd64}
  };

  localparam logic [63:0] PERS [3] = '{64'd100, 64'd250, 64'd40};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // observe outputs caused by the previous cycle, then drive the next one
  task automatic cyc(input logic [63:0] t, input logic tk, input logic we,
                     input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    o_alm = alarm_o; o_pul = pulse_o; o_irq = irq_o; o_t = time_i; o_tk = tick_i;
    time_i = t; tick_i = tk; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(time_i, 1'b0, 1'b1, a, d);
  endtask

  task automatic tk(input logic [63:0] t);
    cyc(t, 1'b1, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic idle();
    cyc(time_i, 1'b0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic pulse_run(input logic [63:0] tstart, input logic [63:0] anc,
                           input int n, input string req);
    int mis [3];
    int cnt [3];
    int ecnt [3];
    for (int c = 0; c < 3; c++) begin mis[c] = 0; cnt[c] = 0; ecnt[c] = 0; end
    for (int i = 0; i <= n; i++) begin
      if (i < n) tk(tstart + 64'(i) * 64'd10);
      else idle();
      if (i > 0) begin
        for (int c = 0; c < 3; c++) begin
          logic e;
          e = o_tk && (o_t > anc) && (((o_t - anc) % PERS[c]) == 0);
          if (o_pul[c] !== e) mis[c]++;
          if (o_pul[c]) cnt[c]++;
          if (e) ecnt[c]++;
        end
      end
    end
    for (int c = 0; c < 3; c++) begin
      chk(req, 64'(cnt[c]), 64'(ecnt[c]));
      chk(req, 64'(mis[c]), 64'd0);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 alarm", 64'(alarm_o), 64'd0);
    chk("R1 pulse", 64'(pulse_o), 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);
    rst_ni = 1'b1;
    tk(64'd1000); tk(64'd2000); idle();
    chk("R1 disarmed", 64'(o_alm), 64'd0);

    // R2 R3 alarm compare vectors
    for (int v = 0; v < 5; v++) begin
      int first_hit;
      int hits;
      logic [63:0] expk;
      first_hit = -1; hits = 0;
      expk = (VECS[v].t0 >= VECS[v].alm) ? 64'd0 :
             (VECS[v].alm - VECS[v].t0 + VECS[v].stp - 64'd1) / VECS[v].stp;
      wr(4'd3, VECS[v].alm[31:0]);
      wr(4'd4, VECS[v].alm[63:32]);
      for (int k = 0; k <= 21; k++) begin
        if (k <= 20) tk(VECS[v].t0 + 64'(k) * VECS[v].stp);
        else idle();
        if (k > 0 && o_alm[0]) begin
          hits++;
          if (first_hit < 0) first_hit = k - 1;
        end
      end
      chk("R2 first match", 64'(first_hit), expk);
      chk("R3 single match", 64'(hits), 64'd1);
    end

    // R4 no compare without tick
    wr(4'd3, 32'd200); wr(4'd4, 32'd0);
    begin
      int seen;
      seen = 0;
      cyc(64'd300, 1'b0, 1'b0, 4'd0, 32'd0);
      for (int i = 0; i < 3; i++) begin
        cyc(64'd300, 1'b0, 1'b0, 4'd0, 32'd0);
        if (o_alm[0]) seen++;
      end
      tk(64'd300);
      if (o_alm[0]) seen++;
      chk("R4 no match without tick", 64'(seen), 64'd0);
      idle();
      chk("R4 match on tick", 64'(o_alm[0]), 64'd1);
    end

    // R5 polarity of alarm 1
    wr(4'd0, 32'h4000_0000);
    idle();
    chk("R5 idle inverted", 64'(o_alm), 64'b10);
    wr(4'd5, 32'd500); wr(4'd6, 32'd0);
    tk(64'd490); tk(64'd500); idle();
    chk("R5 active low pulse", 64'(o_alm), 64'b00);
    idle();
    chk("R5 back to idle", 64'(o_alm), 64'b10);
    wr(4'd0, 32'd0);

    // R6 R7 events, W1C and mask
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0001_0000);
    idle();
    chk("R6 cleared", 64'(o_irq), 64'd0);
    wr(4'd3, 32'd7000); wr(4'd4, 32'd0);
    tk(64'd6990); tk(64'd7000); idle();
    chk("R6 alarm event irq", 64'(o_irq), 64'd1);
    wr(4'd1, 32'h0002_0000);
    idle();
    chk("R6 other bit clear no effect", 64'(o_irq), 64'd1);
    wr(4'd1, 32'h0001_0000);
    idle();
    chk("R6 W1C clears", 64'(o_irq), 64'd0);
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd7100); wr(4'd4, 32'd0);
    tk(64'd7100); idle();
    chk("R7 masked no irq", 64'(o_irq), 64'd0);
    wr(4'd2, 32'h0001_0000);
    idle();
    chk("R7 pending after unmask", 64'(o_irq), 64'd1);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'd0);

    // R9 aligned pulses
    wr(4'd7, 32'd100); wr(4'd8, 32'd250); wr(4'd9, 32'd40);
    wr(4'd0, 32'h1000_0000);
    wr(4'd3, 32'd990); wr(4'd4, 32'd0);
    pulse_run(64'd900, 64'd990, 80, "R9 aligned pulses");
    wr(4'd2, 32'h0000_0040);
    idle();
    chk("R6 pulse event irq", 64'(o_irq), 64'd1);

    // R8 stop
    wr(4'd0, 32'd0);
    wr(4'd1, 32'h0000_0040);
    idle();
    chk("R8 event cleared", 64'(o_irq), 64'd0);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i <= 30; i++) begin
        if (i < 30) tk(64'd2000 + 64'(i) * 64'd10);
        else idle();
        if (i > 0 && o_pul != 3'b000) seen++;
      end
      chk("R8 no pulses when stopped", 64'(seen), 64'd0);
      chk("R8 irq stays low", 64'(o_irq), 64'd0);
    end

    // R10 realignment disabled
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd5055); wr(4'd4, 32'd0);
    wr(4'd0, 32'h1000_4000);
    pulse_run(64'd5000, 64'd5000, 80, "R10 free anchor");

    finish_run();
  end
endmodule